// File: doc/BRIEF.md
# Complementary PWM pair with dead-band insertion

This block turns an up-counting timebase into one edge-aligned PWM channel and its inverted companion, ready for the output-enable stage that sits in front of a half-bridge. A prescaler divides the clock. A counter then runs from zero up to a programmed period value, wraps, and emits a one-clock update pulse. A reference waveform is high while the count is below a compare value. The primary gate follows the reference and the secondary gate follows its inverse.

A single dead-band timer sits between the reference and the gates. On every reference edge the gate that is switching off drops in the next clock. The gate that is switching on waits a programmed number of dead-band ticks first, where each tick is a fixed number of clocks. As a result the two gates are never high together, and both low-low gaps in a period come from the same timer. The period and compare inputs are held in shadow registers that are loaded only at the wrap. Software can therefore change them at any time without producing a truncated pulse.

Top module: `cpwm_deadband`

## Requirements
- R1: While the reset input is low, both gate outputs and the update pulse are low, whatever the other inputs are.
- R2: With counting enabled, the update pulse is exactly one clock wide and repeats every (period+1)·(prescale+1) clocks.
- R3: Over one period the reference is high for min(compare, period+1)·(prescale+1) clocks, starting at the update. A compare of 0 keeps the primary gate low for the whole period. A compare above the period value keeps it high for the whole period.
- R4: Both gates are active-high. With a dead-band code of 0 the primary gate equals the reference and the secondary gate equals its inverse, each one clock after the reference.
- R5: When the reference changes, the gate turning off goes low one clock later. The gate turning on goes high DT_DIV·code clocks after that, so each gate's high time per period is its reference phase minus DT_DIV·code.
- R6: The gap after a rising reference edge and the gap after a falling reference edge have the same length, because both come from one shared dead-band timer.
- R7: The primary and secondary gates are never high in the same clock.
- R8: New period and compare values take effect only at the next update. The period in progress finishes with the old values.
- R9: The dead-band timer restarts on every reference edge. If the dead time is equal to or longer than a reference phase, the gate that would turn on stays low for that entire phase.
- R10: Each gate has its own enable. A disabled gate is held low, and the other gate behaves as if the enable had not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | Counting enable |
| presc_i | input | PSC_W | Prescale value; the counter steps every presc_i+1 clocks |
| period_i | input | CNT_W | Period value, shadowed at update |
| cmp_i | input | CNT_W | Compare value, shadowed at update |
| dead_code_i | input | DT_W | Dead-band length in ticks of DT_DIV clocks |
| en_p_i | input | 1 | Primary gate enable |
| en_n_i | input | 1 | Secondary gate enable |
| pwm_p_o | output | 1 | Primary gate, high while the reference is high, after the dead band |
| pwm_n_o | output | 1 | Secondary gate, high while the reference is low, after the dead band |
| upd_o | output | 1 | One-clock pulse at each counter wrap |

## Verification
The bench builds the block with a 10-bit counter, a 4-bit prescaler, an 8-bit dead-band code and DT_DIV of 4. These values keep each period to a few dozen clocks, so many whole periods fit in a short run. They still allow a dead band as long as a whole reference phase, and the exact equal case is one of the tests. Counting gate-high clocks between update pulses exposes period, duty and both dead-band gaps in a single measurement. With a prescale of 1 the prescaler's effect on period and phase lengths is visible as well.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  // Gate pair driven toward the output-enable stage.
  typedef struct packed {
    logic prim;
    logic sec;
  } gate_pair_t;

endpackage

// File: rtl/cpwm_rst_sync.sv
module cpwm_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] presc_i,
  output logic             tick_o
);

  localparam logic [PSC_W-1:0] ONE = PSC_W'(1);

  logic [PSC_W-1:0] div_q, div_d;
  logic             at_end;

  // Next-state: count 0..presc_i, tick on the last count.
  always_comb begin
    at_end = (div_q >= presc_i);
    div_d  = div_q;
    if (run_i) begin
      div_d = at_end ? '0 : div_q + ONE;
    end
  end

  assign tick_o = run_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             ref_o,
  output logic             upd_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             upd_q, upd_d;
  logic             wrap;

  // Next-state: shadow registers load only on the wrap.
  always_comb begin
    wrap  = tick_i && (cnt_q == per_q);
    cnt_d = cnt_q;
    per_d = per_q;
    cmp_d = cmp_q;
    upd_d = 1'b0;
    if (tick_i) begin
      if (wrap) begin
        cnt_d = '0;
        per_d = period_i;
        cmp_d = cmp_i;
        upd_d = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      cmp_q <= '0;
      upd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      cmp_q <= cmp_d;
      upd_q <= upd_d;
    end
  end

  assign ref_o = (cnt_q < cmp_q);
  assign upd_o = upd_q;

  // R2: count never passes the active period value
  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= per_q);

  // R2: update marks the first count of a new period
  a_r2_update_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> (cnt_q == '0));

  // R8: shadows hold unless the counter is wrapping
  a_r8_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && (cnt_q == per_q)) |=> ($stable(per_q) && $stable(cmp_q)));

endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime
  import cpwm_pkg::*;
#(
  parameter int DT_W   = 8,
  parameter int DT_DIV = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_i,
  input  logic [DT_W-1:0] code_i,
  input  logic            en_p_i,
  input  logic            en_n_i,
  output gate_pair_t      gates_o
);

  localparam int DIV_W = (DT_DIV > 1) ? $clog2(DT_DIV) : 1;

  logic            ref_q;
  logic [DT_W-1:0] rem_q, rem_d;
  gate_pair_t      gates_q, gates_d;
  logic            edge_s;
  logic            step;
  logic            open_s;

  assign edge_s = ref_i ^ ref_q;

  // Tick divider variant picked by DT_DIV.
  generate
    if (DT_DIV > 1) begin : g_div
      localparam logic [DIV_W-1:0] LAST = DIV_W'(DT_DIV - 1);
      localparam logic [DIV_W-1:0] ONE  = DIV_W'(1);
      logic [DIV_W-1:0] div_q, div_d;

      always_comb begin
        div_d = div_q;
        if (edge_s)             div_d = '0;
        else if (rem_q != '0)   div_d = (div_q == LAST) ? '0 : div_q + ONE;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
      end

      assign step = (div_q == LAST);
    end else begin : g_nodiv
      assign step = 1'b1;
    end
  endgenerate

  // Next-state: reload on any reference edge, count down otherwise.
  always_comb begin
    rem_d = rem_q;
    if (edge_s)                      rem_d = code_i;
    else if ((rem_q != '0) && step)  rem_d = rem_q - DT_W'(1);
    open_s       = (rem_d == '0);
    gates_d.prim = en_p_i &  ref_i & open_s;
    gates_d.sec  = en_n_i & ~ref_i & open_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= 1'b0;
      rem_q   <= '0;
      gates_q <= '0;
    end else begin
      ref_q   <= ref_i;
      rem_q   <= rem_d;
      gates_q <= gates_d;
    end
  end

  assign gates_o = gates_q;

  // R7: gates never high together
  a_r7_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gates_q.prim && gates_q.sec));

  // R5: with a nonzero dead band the other gate was already low
  a_r5_gap_before_prim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((code_i != '0) && $rose(gates_q.prim)) |-> !$past(gates_q.sec));

  // R6: the same gap rule holds for the secondary side
  a_r6_gap_before_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((code_i != '0) && $rose(gates_q.sec)) |-> !$past(gates_q.prim));

  // R10: a disabled gate stays low
  a_r10_prim_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_p_i |=> !gates_q.prim);

  a_r10_sec_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_n_i |=> !gates_q.sec);

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband
  import cpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DT_W   = 8,
  parameter int DT_DIV = 4
) (
  input  logic             clk_i,
  input  logic             arst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] presc_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [DT_W-1:0]  dead_code_i,
  input  logic             en_p_i,
  input  logic             en_n_i,
  output logic             pwm_p_o,
  output logic             pwm_n_o,
  output logic             upd_o
);

  logic       rst_n;
  logic       tick;
  logic       ref_s;
  gate_pair_t gates;

  cpwm_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_n)
  );

  cpwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .run_i   (run_i),
    .presc_i (presc_i),
    .tick_o  (tick)
  );

  cpwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .period_i (period_i),
    .cmp_i    (cmp_i),
    .ref_o    (ref_s),
    .upd_o    (upd_o)
  );

  cpwm_deadtime #(.DT_W(DT_W), .DT_DIV(DT_DIV)) u_dt (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .ref_i   (ref_s),
    .code_i  (dead_code_i),
    .en_p_i  (en_p_i),
    .en_n_i  (en_n_i),
    .gates_o (gates)
  );

  assign pwm_p_o = gates.prim;
  assign pwm_n_o = gates.sec;

  // R1: reset holds all outputs low
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_n |-> (!pwm_p_o && !pwm_n_o && !upd_o));

endmodule

// File: tb/cpwm_deadband_test.sv
module cpwm_deadband_test;

  localparam int CW = 10;
  localparam int PW = 4;
  localparam int DW = 8;
  localparam int DD = 4;

  logic          clk = 1'b0;
  logic          arst_n = 1'b0;
  logic          run = 1'b0;
  logic [PW-1:0] presc = '0;
  logic [CW-1:0] per = '0;
  logic [CW-1:0] cmpv = '0;
  logic [DW-1:0] dcode = '0;
  logic          en_p = 1'b0;
  logic          en_n = 1'b0;
  logic          pwm_p, pwm_n, upd;

  cpwm_deadband #(.CNT_W(CW), .PSC_W(PW), .DT_W(DW), .DT_DIV(DD)) uut (
    .clk_i       (clk),
    .arst_ni     (arst_n),
    .run_i       (run),
    .presc_i     (presc),
    .period_i    (per),
    .cmp_i       (cmpv),
    .dead_code_i (dcode),
    .en_p_i      (en_p),
    .en_n_i      (en_n),
    .pwm_p_o     (pwm_p),
    .pwm_n_o     (pwm_n),
    .upd_o       (upd)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    period;
    int    hi_p;
    int    hi_n;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int   checks = 0;
  int   errors = 0;
  int   nwin = 0;
  int   w_len, w_p, w_n, w_ovl;
  bit   started = 1'b0;
  bit   done = 1'b0;

  function automatic void chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endfunction

  // Monitor: measure each update-to-update window and score it.
  always @(negedge clk) begin
    if (!arst_n) begin
      started = 1'b0;
    end else begin
      if (upd) begin
        if (started) begin
          if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            chk(w_len == cur.period, "R2", "period clocks", w_len, cur.period);
            if (cur.hi_p >= 0) chk(w_p == cur.hi_p, cur.tag, "primary high clocks", w_p, cur.hi_p);
            if (cur.hi_n >= 0) chk(w_n == cur.hi_n, cur.tag, "secondary high clocks", w_n, cur.hi_n);
            chk(w_ovl == 0, "R7", "overlap clocks", w_ovl, 0);
          end
          nwin++;
        end
        started = 1'b1;
        w_len = 0; w_p = 0; w_n = 0; w_ovl = 0;
      end
      if (started) begin
        w_len++;
        w_p   += int'(pwm_p);
        w_n   += int'(pwm_n);
        w_ovl += int'(pwm_p & pwm_n);
      end
    end
  end

  // Driver: program a case, let it settle, queue the expected windows.
  task automatic run_case(string tag, int p, int a, int c, int d, bit ep, bit en, int nw);
    int base, prd, hi, lo, dt, xp, xn;
    presc = PW'(p); per = CW'(a); cmpv = CW'(c); dcode = DW'(d);
    en_p = ep; en_n = en;
    base = nwin;
    wait (nwin >= base + 3);
    prd = (a + 1) * (p + 1);
    hi  = ((c > a + 1) ? (a + 1) : c) * (p + 1);
    lo  = prd - hi;
    dt  = DD * d;
    if (!ep)          xp = 0;
    else if (lo == 0) xp = prd;
    else if (hi == 0) xp = 0;
    else              xp = (hi > dt) ? hi - dt : 0;
    if (!en)          xn = 0;
    else if (hi == 0) xn = prd;
    else if (lo == 0) xn = 0;
    else              xn = (lo > dt) ? lo - dt : 0;
    for (int i = 0; i < nw; i++) exp_q.push_back('{prd, xp, xn, tag});
    wait (exp_q.size() == 0);
  endtask

  initial begin
    int base;
    run = 1'b1; en_p = 1'b1; en_n = 1'b1;
    presc = '0; per = CW'(19); cmpv = CW'(12); dcode = DW'(1);
    // R1: outputs quiet while reset is held
    repeat (4) begin
      @(negedge clk);
      chk(!pwm_p && !pwm_n && !upd, "R1", "outputs during reset",
          int'({pwm_p, pwm_n, upd}), 0);
    end
    arst_n = 1'b1;

    run_case("R5", 0, 19, 12, 1, 1'b1, 1'b1, 3);
    run_case("R5 R6", 1, 24, 10, 2, 1'b1, 1'b1, 3);
    run_case("R4", 0, 15, 5, 0, 1'b1, 1'b1, 3);
    run_case("R3", 0, 9, 0, 1, 1'b1, 1'b1, 2);
    run_case("R3", 0, 9, 12, 1, 1'b1, 1'b1, 2);
    run_case("R9", 0, 29, 6, 2, 1'b1, 1'b1, 3);
    run_case("R9", 0, 19, 8, 2, 1'b1, 1'b1, 2);
    run_case("R10", 0, 19, 12, 1, 1'b0, 1'b1, 2);
    run_case("R10", 0, 19, 12, 1, 1'b1, 1'b0, 2);

    // R8: change period and compare right after an update
    run_case("R8", 0, 19, 12, 1, 1'b1, 1'b1, 1);
    base = nwin;
    wait (nwin > base);
    per = CW'(39); cmpv = CW'(30);
    exp_q.push_back('{20, 8, -1, "R8"});
    exp_q.push_back('{40, 26, -1, "R8"});
    wait (exp_q.size() == 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", "run timed out", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule